// File: doc/BRIEF.md
# RS-485 Half-Duplex Buffered UART

This block is a byte-oriented serial transceiver for a two-wire RS-485 segment where only one node may drive the pair at a time. The host loads outgoing bytes through a push stream into a transmit queue. It takes incoming bytes from a receive queue through a pop stream that never stalls. The block frames each byte as 8 data bits, no parity and one stop bit, least significant bit first. It drives the transceiver's driver-enable pin itself, so the host never handles direction control.

Driver-enable rises as soon as the transmit queue holds data. One idle-high guard bit is then sent so the transceiver can settle before the first start bit. Queued bytes go out back to back. Driver-enable drops only once the queue is empty and the last stop bit has been fully sent. While driving, the receiver ignores its own echo. Both queues keep one slot free, so each holds at most 2^QAW-1 bytes. Overflow and framing problems are collected in one sticky status word that the host clears with a pulse.

Top module: `rs485_uart`

## Requirements
- R1: While reset is asserted and right after it is released, de is 0, txd is 1, rx_valid is 0, tx_ready is 1 and status is 0.
- R2: Each transmitted byte is one low start bit, 8 data bits LSB first, and one high stop bit. Every bit lasts exactly 16*D clock cycles, where D = max(1, CLK_HZ / (16*rate)). txd is 1 whenever de is 0.
- R3: The rate is chosen by the baud_sel code latched on a baud_load pulse: 0=9600, 1=19200, 2=38400, 3=57600, 4=115200, 5=230400, 6 or 7=115200. After reset the rate is 115200.
- R4: de rises one cycle after the transmit queue turns non-empty. The first start bit begins between 15*D+1 and 16*D cycles after de rises, with txd high in between. No byte leaves the queue while de is 0.
- R5: Bytes queued together go out back to back, with start bits 160*D cycles apart. de falls exactly at the end of the last stop bit, and only when the transmit queue is empty.
- R6: The transmit queue holds 255 bytes. A byte is taken when tx_valid and tx_ready are both high. tx_ready is low when the queue is full. tx_valid with tx_ready low drops the byte and sets status bit 1.
- R7: A well-formed 8N1 frame on rxd at the selected rate is queued. Bytes are presented on rx_data with rx_valid high, oldest first. A byte is removed when rx_valid and rx_ready are both high.
- R8: rx_ready while rx_valid is 0 has no effect: no status change, and the next received byte is presented correctly.
- R9: The receive queue holds 255 bytes. A byte that arrives while it is full is discarded and sets status bit 0.
- R10: A frame whose stop bit samples low is discarded and sets status bit 2.
- R11: Activity on rxd while de is 1 is neither queued nor flagged.
- R12: status bits stay set until a status_clr pulse clears them all. A new event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_sel | input | 3 | Rate code to latch |
| baud_load | input | 1 | Latch baud_sel as the active rate |
| tx_valid | input | 1 | Push request for the transmit queue |
| tx_ready | output | 1 | Transmit queue has room |
| tx_data | input | 8 | Byte to push |
| rx_valid | output | 1 | Receive queue holds a byte |
| rx_ready | input | 1 | Pop the presented byte |
| rx_data | output | 8 | Oldest received byte |
| status | output | 3 | Sticky flags: bit0 rx overflow, bit1 tx overflow, bit2 framing error |
| status_clr | input | 1 | Clear all status flags |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |
| de | output | 1 | Transceiver driver-enable, high while transmitting |

## Verification
The assertions assume the rate is changed only while de is low and no frame is arriving. They also assume rxd frames follow the selected rate closely enough to be sampled at mid-bit. The stimulus issues baud_load only between bursts, with the line idle. It drives rxd from a bit period computed in the bench for the current code. A malformed stop bit is produced only at a rate where the trailing low half-bit is rejected as a false start.

// File: rtl/rs485_pkg.sv
package rs485_pkg;
  localparam int unsigned OVS = 16;

  typedef enum logic [2:0] {
    BAUD_9600   = 3'd0,
    BAUD_19200  = 3'd1,
    BAUD_38400  = 3'd2,
    BAUD_57600  = 3'd3,
    BAUD_115200 = 3'd4,
    BAUD_230400 = 3'd5
  } baud_e;

  typedef enum logic [2:0] {T_IDLE, T_GUARD, T_START, T_DATA, T_STOP} tx_state_e;
  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rx_state_e;

  function automatic int unsigned rate_of(input logic [2:0] code);
    case (code)
      3'd0:    return 9600;
      3'd1:    return 19200;
      3'd2:    return 38400;
      3'd3:    return 57600;
      3'd5:    return 230400;
      default: return 115200;
    endcase
  endfunction

  function automatic int unsigned div_for(input int unsigned clk_hz, input logic [2:0] code);
    int unsigned d;
    d = clk_hz / (rate_of(code) * OVS);
    if (d == 0) d = 1;
    return d;
  endfunction
endpackage

// File: rtl/rs485_baud.sv
module rs485_baud #(
  parameter int unsigned CLK_HZ = 50_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  output logic       tick
);
  import rs485_pkg::*;
  localparam int unsigned DMAX = div_for(CLK_HZ, 3'd0);
  localparam int DW = $clog2(DMAX + 1);

  logic [DW-1:0] div_tab [8];
  logic [DW-1:0] cnt;

  for (genvar g = 0; g < 8; g++) begin : g_div
    assign div_tab[g] = DW'(div_for(CLK_HZ, 3'(g)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div_tab[sel] - DW'(1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + DW'(1);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/rs485_fifo.sv
module rs485_fifo #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          full,
  output logic          drop
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] head, tail;
  logic do_wr, do_rd;

  assign empty   = (head == tail);
  assign full    = (AW'(head + 1'b1) == tail);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign drop    = wr_en && full;
  assign rd_data = mem[tail];

  always_ff @(posedge clk) begin
    if (do_wr) mem[head] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else begin
      if (do_wr) head <= head + 1'b1;
      if (do_rd) tail <= tail + 1'b1;
    end
  end

  // R6
  full_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> (full && $stable(head)));

  // R8
  empty_read_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !wr_en) |=> (empty && $stable(tail)));
endmodule

// File: rtl/rs485_tx.sv
module rs485_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       q_empty,
  input  logic [7:0] q_data,
  output logic       q_pop,
  output logic       txd,
  output logic       de
);
  import rs485_pkg::*;

  tx_state_e  state;
  logic [3:0] tcnt;
  logic [2:0] bidx;
  logic [7:0] shr;
  logic       bit_end;

  assign bit_end = tick && (tcnt == 4'hF);
  assign q_pop   = bit_end && ((state == T_GUARD) || (state == T_STOP && !q_empty));

  always_comb begin
    case (state)
      T_START: txd = 1'b0;
      T_DATA:  txd = shr[0];
      default: txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= T_IDLE;
      de    <= 1'b0;
      tcnt  <= 4'd0;
      bidx  <= 3'd0;
      shr   <= 8'd0;
    end else if (state == T_IDLE) begin
      if (!q_empty) begin
        de    <= 1'b1;
        state <= T_GUARD;
        tcnt  <= 4'd0;
      end
    end else begin
      if (tick) tcnt <= tcnt + 4'd1;
      if (bit_end) begin
        case (state)
          T_GUARD: begin
            shr   <= q_data;
            state <= T_START;
          end
          T_START: begin
            bidx  <= 3'd0;
            state <= T_DATA;
          end
          T_DATA: begin
            shr  <= {1'b0, shr[7:1]};
            bidx <= bidx + 3'd1;
            if (bidx == 3'd7) state <= T_STOP;
          end
          default: begin
            if (!q_empty) begin
              shr   <= q_data;
              state <= T_START;
            end else begin
              state <= T_IDLE;
              de    <= 1'b0;
            end
          end
        endcase
      end
    end
  end

  // R4
  pop_under_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop |-> de);

  // R5
  de_fall_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(de) |-> $past(q_empty));

  // R2
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> txd);

  // R4
  guard_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de) |=> txd);
endmodule

// File: rtl/rs485_rx.sv
module rs485_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic       de,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       frame_err
);
  import rs485_pkg::*;

  rx_state_e  state;
  logic [1:0] sync;
  logic       rx_s;
  logic [3:0] cnt;
  logic [2:0] bidx;
  logic [7:0] shr;

  assign rx_s      = sync[1];
  assign byte_data = shr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= R_IDLE;
      cnt        <= 4'd0;
      bidx       <= 3'd0;
      shr        <= 8'd0;
      byte_valid <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      frame_err  <= 1'b0;
      if (de) begin
        state <= R_IDLE;
        cnt   <= 4'd0;
      end else if (tick) begin
        case (state)
          R_IDLE: begin
            if (!rx_s) begin
              state <= R_START;
              cnt   <= 4'd0;
            end
          end
          R_START: begin
            if (cnt == 4'd7) begin
              cnt   <= 4'd0;
              bidx  <= 3'd0;
              state <= rx_s ? R_IDLE : R_DATA;
            end else cnt <= cnt + 4'd1;
          end
          R_DATA: begin
            if (cnt == 4'hF) begin
              cnt  <= 4'd0;
              shr  <= {rx_s, shr[7:1]};
              bidx <= bidx + 3'd1;
              if (bidx == 3'd7) state <= R_STOP;
            end else cnt <= cnt + 4'd1;
          end
          default: begin
            if (cnt == 4'hF) begin
              cnt   <= 4'd0;
              state <= R_IDLE;
              if (rx_s) byte_valid <= 1'b1;
              else      frame_err  <= 1'b1;
            end else cnt <= cnt + 4'd1;
          end
        endcase
      end
    end
  end

  // R11
  echo_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(de) |-> (!byte_valid && !frame_err));
endmodule

// File: rtl/rs485_uart.sv
module rs485_uart #(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int          QAW    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] baud_sel,
  input  logic       baud_load,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [7:0] tx_data,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic [7:0] rx_data,
  output logic [2:0] status,
  input  logic       status_clr,
  output logic       txd,
  input  logic       rxd,
  output logic       de
);
  import rs485_pkg::*;

  logic [2:0] rate_q;
  logic       tick;
  logic       tx_empty, tx_full, tx_drop, tx_pop;
  logic [7:0] tx_q_data;
  logic       rx_push, rx_empty, rx_full, rx_drop, rx_ferr;
  logic [7:0] rx_byte;
  logic [2:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rate_q <= BAUD_115200;
    else if (baud_load) rate_q <= baud_sel;
  end

  rs485_baud #(.CLK_HZ(CLK_HZ)) u_baud (
    .clk(clk), .rst_n(rst_n), .sel(rate_q), .tick(tick)
  );

  rs485_fifo #(.AW(QAW), .DW(8)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tx_valid), .wr_data(tx_data),
    .rd_en(tx_pop), .rd_data(tx_q_data),
    .empty(tx_empty), .full(tx_full), .drop(tx_drop)
  );

  rs485_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .q_empty(tx_empty), .q_data(tx_q_data), .q_pop(tx_pop),
    .txd(txd), .de(de)
  );

  rs485_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .de(de),
    .byte_valid(rx_push), .byte_data(rx_byte), .frame_err(rx_ferr)
  );

  rs485_fifo #(.AW(QAW), .DW(8)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .wr_en(rx_push), .wr_data(rx_byte),
    .rd_en(rx_ready), .rd_data(rx_data),
    .empty(rx_empty), .full(rx_full), .drop(rx_drop)
  );

  assign tx_ready = !tx_full;
  assign rx_valid = !rx_empty;
  assign status   = stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 3'b000;
    else begin
      stat_q[0] <= (stat_q[0] & ~status_clr) | rx_drop;
      stat_q[1] <= (stat_q[1] & ~status_clr) | tx_drop;
      stat_q[2] <= (stat_q[2] & ~status_clr) | rx_ferr;
    end
  end

  // R9
  rx_full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && rx_push && !rx_ready) |=> status[0]);

  // R6
  tx_push_full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> status[1]);
endmodule

// File: tb/tb_rs485_uart.sv
module tb_rs485_uart;
  localparam int unsigned BCLK = 3_686_400;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] baud_sel = 3'd4;
  logic       baud_load = 1'b0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = 8'd0;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic [2:0] status;
  logic       status_clr = 1'b0;
  logic       txd;
  logic       rxd = 1'b1;
  logic       de;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int de_rise = 0;
  bit de_q = 1'b0;

  rs485_uart #(.CLK_HZ(BCLK), .QAW(8)) dut (
    .clk(clk), .rst_n(rst_n), .baud_sel(baud_sel), .baud_load(baud_load),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .status(status), .status_clr(status_clr),
    .txd(txd), .rxd(rxd), .de(de)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (de === 1'b1 && !de_q) de_rise = cyc;
    de_q = (de === 1'b1);
  end

  function automatic int exp_div(input int code);
    int rate;
    case (code)
      0: rate = 9600;
      1: rate = 19200;
      2: rate = 38400;
      3: rate = 57600;
      5: rate = 230400;
      default: rate = 115200;
    endcase
    exp_div = int'(BCLK) / (rate * 16);
    if (exp_div < 1) exp_div = 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_baud(input int code);
    @(negedge clk);
    baud_sel = 3'(code);
    baud_load = 1'b1;
    @(negedge clk);
    baud_load = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data = b;
  endtask

  task automatic push_end();
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic line_rx(input int bp, output logic [7:0] b, output int t0);
    do @(negedge clk); while (txd !== 1'b0);
    t0 = cyc;
    repeat (bp / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (bp) @(negedge clk);
      b[i] = txd;
    end
    repeat (bp) @(negedge clk);
    check(txd === 1'b1, "R2 stop bit high", int'(txd), 1);
  endtask

  task automatic line_tx(input logic [7:0] b, input bit good_stop, input int bp);
    @(negedge clk);
    rxd = 1'b0;
    repeat (bp) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (bp) @(negedge clk);
    end
    rxd = good_stop;
    repeat (bp) @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic pop_chk(input logic [7:0] exp, input string req);
    @(negedge clk);
    check(rx_valid === 1'b1, req, int'(rx_valid), 1);
    check(rx_data === exp, req, int'(rx_data), int'(exp));
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic tx_burst(input int code, input int n, input string tag);
    logic [7:0] v [4];
    logic [7:0] got;
    int t0, tprev, d, bp;
    d = exp_div(code);
    bp = 16 * d;
    tprev = 0;
    for (int i = 0; i < n; i++) begin
      v[i] = 8'($urandom);
      push(v[i]);
    end
    push_end();
    for (int i = 0; i < n; i++) begin
      line_rx(bp, got, t0);
      check(got === v[i], {tag, " R2 byte"}, int'(got), int'(v[i]));
      if (i == 0)
        check((t0 - de_rise) >= 15 * d + 1 && (t0 - de_rise) <= 16 * d,
              "R4 guard length", t0 - de_rise, 16 * d);
      else
        check((t0 - tprev) == 10 * bp, "R5 back to back", t0 - tprev, 10 * bp);
      tprev = t0;
    end
    repeat (bp / 2 - 1) @(negedge clk);
    check(de === 1'b1, "R5 de held through stop", int'(de), 1);
    @(negedge clk);
    check(de === 1'b0, "R5 de falls at stop end", int'(de), 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int bp, code;
    logic [7:0] rv [4];
    void'($urandom(32'd2718));

    // R1 reset state
    repeat (2) @(negedge clk);
    check(de === 1'b0 && txd === 1'b1, "R1 line in reset", int'({de, txd}), 1);
    do_reset();
    @(negedge clk);
    check(de === 1'b0, "R1 de", int'(de), 0);
    check(txd === 1'b1, "R1 txd", int'(txd), 1);
    check(rx_valid === 1'b0, "R1 rx_valid", int'(rx_valid), 0);
    check(tx_ready === 1'b1, "R1 tx_ready", int'(tx_ready), 1);
    check(status === 3'b000, "R1 status", int'(status), 0);

    // R3 default rate 115200, then random rates
    tx_burst(4, 1, "R3 default");
    for (int k = 0; k < 6; k++) begin
      code = 2 + int'($urandom % 4);
      set_baud(code);
      tx_burst(code, 1 + int'($urandom % 3), "R3 random rate");
    end
    set_baud(7);
    tx_burst(7, 2, "R3 code7");
    set_baud(1);
    tx_burst(1, 1, "R3 19200");

    // R7 receive random bytes at random rate
    code = 2 + int'($urandom % 4);
    set_baud(code);
    bp = 16 * exp_div(code);
    for (int i = 0; i < 4; i++) begin
      rv[i] = 8'($urandom);
      line_tx(rv[i], 1'b1, bp);
    end
    repeat (bp) @(negedge clk);
    for (int i = 0; i < 4; i++) pop_chk(rv[i], "R7 rx order");

    // R8 pop while empty
    @(negedge clk);
    check(rx_valid === 1'b0, "R8 empty", int'(rx_valid), 0);
    rx_ready = 1'b1;
    repeat (3) @(negedge clk);
    rx_ready = 1'b0;
    check(rx_valid === 1'b0 && status === 3'b000, "R8 empty pop no effect", int'(status), 0);
    line_tx(8'h5A, 1'b1, bp);
    repeat (bp) @(negedge clk);
    pop_chk(8'h5A, "R8 next byte intact");

    // R10 framing error at 115200
    set_baud(4);
    bp = 16 * exp_div(4);
    line_tx(8'hC3, 1'b0, bp);
    repeat (2 * bp) @(negedge clk);
    check(rx_valid === 1'b0, "R10 bad frame dropped", int'(rx_valid), 0);
    check(status === 3'b100, "R10 frame flag", int'(status), 4);
    repeat (5) @(negedge clk);
    check(status === 3'b100, "R12 flag sticky", int'(status), 4);
    status_clr = 1'b1;
    @(negedge clk);
    status_clr = 1'b0;
    check(status === 3'b000, "R12 clear", int'(status), 0);
    line_tx(8'h81, 1'b1, bp);
    repeat (bp) @(negedge clk);
    pop_chk(8'h81, "R10 recovery");

    // R11 echo ignored
    push(8'h77);
    push_end();
    do @(negedge clk); while (de !== 1'b1);
    line_tx(8'h3C, 1'b1, bp);
    do @(negedge clk); while (de !== 1'b0);
    repeat (2 * bp) @(negedge clk);
    check(rx_valid === 1'b0, "R11 echo not queued", int'(rx_valid), 0);
    check(status === 3'b000, "R11 echo not flagged", int'(status), 0);

    // R9 receive overflow at 230400
    set_baud(5);
    bp = 16 * exp_div(5);
    for (int i = 0; i < 256; i++) line_tx(8'(i), 1'b1, bp);
    repeat (bp) @(negedge clk);
    check(status === 3'b001, "R9 rx overflow flag", int'(status), 1);
    for (int i = 0; i < 255; i++) begin
      @(negedge clk);
      if (rx_data !== 8'(i) || rx_valid !== 1'b1)
        check(1'b0, "R9 stored order", int'(rx_data), i);
      rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0;
    end
    checks++;
    @(negedge clk);
    check(rx_valid === 1'b0, "R9 last byte discarded", int'(rx_valid), 0);

    // R6 transmit queue full at 9600
    status_clr = 1'b1;
    @(negedge clk);
    status_clr = 1'b0;
    set_baud(0);
    for (int i = 0; i < 255; i++) push(8'(i));
    push_end();
    check(tx_ready === 1'b0, "R6 full after 255", int'(tx_ready), 0);
    check(status[1] === 1'b0, "R6 no flag yet", int'(status[1]), 0);
    push(8'hEE);
    push_end();
    check(status[1] === 1'b1, "R6 overflow flag", int'(status[1]), 1);
    check(tx_ready === 1'b0, "R6 still full", int'(tx_ready), 0);
    check(de === 1'b1 && txd === 1'b1, "R4 guard before first bit", int'({de, txd}), 3);
    do_reset();
    @(negedge clk);
    check(de === 1'b0 && tx_ready === 1'b1 && status === 3'b000, "R1 reset clears",
          int'({de, tx_ready, status}), 8);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule